// File: doc/BRIEF.md
# Coprocessor Pipeline Follower

This block sits on the coprocessor side of a tightly coupled link to a host core. It keeps a shadow copy of the host's fetch, decode and execute pipeline. To stay in step it watches a registered, active-low fetch-request strobe together with a clock enable. Fetched instruction words are captured from a 32-bit bus and then move through decode and execute. While an instruction of its own sits in decode or execute, the block reports its state on two 2-bit handshake buses.

For a coprocessor load or store, the execute handshake alone sets how many words the host transfers. The block first holds the host with a fixed number of wait cycles. It then signals one word at a time and marks the final word. The host supplies two qualifiers. The first is a pass indication, which stays high for as long as a passing instruction waits. The second is a late-cancel indication, which counts in only one cycle of the instruction's life.

Top module: `cpf_follower`

## Requirements
- R1: While rst_ni is low, both handshake outputs read 2'b00 (absent) and both shadow stages are empty. After release, the first word reaches decode only once a full fetch-and-sample sequence has completed.
- R2: The shadow pipeline advances only on a rising edge where clk_en_i is high and fetch_n_i is low. On any other edge the contents of decode stay unchanged.
- R3: The instruction word is captured from instr_i on the first enabled edge after a fetch edge. On each advance, the captured word moves to decode, decode moves to execute, and a new word can be captured on that same edge.
- R4: An instruction is owned when its bits 11:8 equal the parameter CP_ID. hs_dec_o reads 2'b01 for an owned, valid instruction in decode and 2'b00 otherwise. An instruction that is not owned gives 2'b00 on hs_ex_o.
- R5: A transfer instruction (bits 27:25 = 3'b110) first drives hs_ex_o = 2'b01 (wait) for BUSY_CYC enabled cycles. It then drives 2'b10 (go) for each word except the last, then 2'b11 (last) for one cycle, then 2'b00.
- R6: The word count is instruction bits 7:0. A count above MAX_WORDS is capped to MAX_WORDS, and a count of 0 moves one word.
- R7: An owned instruction that is not a transfer drives 2'b11 in its first execute cycle and 2'b00 after the next enabled edge.
- R8: While clk_en_i is low, the execute sequence neither advances nor reacts to pass_i.
- R9: If pass_i is low on an enabled edge while an owned instruction is in execute, the instruction is abandoned and hs_ex_o reads 2'b00 from then on.
- R10: late_cancel_i discards the instruction in execute only on the second enabled edge after the instruction enters execute. On every other edge it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable qualifying every edge |
| fetch_n_i | input | 1 | Registered fetch request, active low |
| instr_i | input | 32 | Fetched instruction word |
| pass_i | input | 1 | Instruction in execute passes its condition |
| late_cancel_i | input | 1 | Discard request for the instruction in execute |
| hs_dec_o | output | 2 | Handshake for the decode stage |
| hs_ex_o | output | 2 | Handshake for the execute stage |

## Verification
Some rules are checked on every cycle by the assertions:
- decode freezes whenever no advance happens;
- a captured word matches the bus value on the edge that sampled it;
- an advance shifts the held word into decode;
- a low pass or a late cancel inside its window clears execute;
- a late cancel outside that window leaves a go cycle running;
- the word count never exceeds the cap.

Other behaviour can only be shown by the bench's scenarios:
- the full wait, go and last code sequence for several word counts;
- the handling of foreign and non-transfer instructions;
- a freeze during an enable-low stretch in the middle of a transfer;
- recovery after a reset taken mid-run.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  localparam int IR_W = 32;

  typedef enum logic [1:0] {
    HS_ABSENT = 2'b00,
    HS_WAIT   = 2'b01,
    HS_GO     = 2'b10,
    HS_LAST   = 2'b11
  } hs_e;

  localparam logic [2:0] XFER_CLASS = 3'b110;

  function automatic logic is_xfer(logic [IR_W-1:0] ir);
    return ir[27:25] == XFER_CLASS;
  endfunction

  function automatic logic [3:0] cp_num(logic [IR_W-1:0] ir);
    return ir[11:8];
  endfunction

  function automatic logic [7:0] word_req(logic [IR_W-1:0] ir);
    return ir[7:0];
  endfunction
endpackage

// File: rtl/cpf_shadow_pipe.sv
module cpf_shadow_pipe
  import cpf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clk_en_i,
  input  logic            fetch_n_i,
  input  logic [IR_W-1:0] instr_i,
  output logic            adv_o,
  output logic            dec_v_o,
  output logic [IR_W-1:0] dec_ir_o
);
  logic            pend_q;
  logic            fch_v_q, dec_v_q;
  logic [IR_W-1:0] fch_ir_q, dec_ir_q;
  logic            adv, smp;

  assign adv = clk_en_i & ~fetch_n_i;
  assign smp = clk_en_i & pend_q;   // word of the last fetch is on the bus

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      fch_v_q  <= 1'b0;
      fch_ir_q <= '0;
      dec_v_q  <= 1'b0;
      dec_ir_q <= '0;
    end else begin
      if (clk_en_i) pend_q <= adv;
      if (smp) fch_ir_q <= instr_i;
      if (smp)      fch_v_q <= 1'b1;
      else if (adv) fch_v_q <= 1'b0;
      if (adv) begin
        dec_v_q  <= fch_v_q;
        dec_ir_q <= fch_ir_q;
      end
    end
  end

  assign adv_o    = adv;
  assign dec_v_o  = dec_v_q;
  assign dec_ir_o = dec_ir_q;

  p_stall_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clk_en_i && !fetch_n_i) |=> $stable(dec_ir_q) && $stable(dec_v_q));

  p_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && pend_q) |=> fch_ir_q == $past(instr_i) && fch_v_q);

  p_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && !fetch_n_i) |=> dec_ir_q == $past(fch_ir_q) && dec_v_q == $past(fch_v_q));
endmodule

// File: rtl/cpf_xfer_seq.sv
module cpf_xfer_seq
  import cpf_pkg::*;
#(
  parameter logic [3:0] CP_ID     = 4'd5,
  parameter int         BUSY_CYC  = 2,
  parameter int         MAX_WORDS = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clk_en_i,
  input  logic            adv_i,
  input  logic            dec_v_i,
  input  logic [IR_W-1:0] dec_ir_i,
  input  logic            pass_i,
  input  logic            late_cancel_i,
  output logic [1:0]      hs_ex_o
);
  localparam int CNT_W  = (MAX_WORDS < 2) ? 1 : $clog2(MAX_WORDS + 1);
  localparam int BUSY_W = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC + 1);

  logic             own, xfer;
  logic [7:0]       req;
  logic [CNT_W-1:0] words_ld, words_q;
  logic [BUSY_W-1:0] busy_ld, busy_q;
  logic             live_q;
  logic [1:0]       age_q;
  logic             cancel;
  hs_e              hs;
  logic             unused_ir_bits;

  assign unused_ir_bits = ^{dec_ir_i[31:28], dec_ir_i[24:12]};

  assign own  = dec_v_i && (cp_num(dec_ir_i) == CP_ID);
  assign xfer = is_xfer(dec_ir_i);
  assign req  = word_req(dec_ir_i);

  always_comb begin
    if (!xfer || req == 8'd0)        words_ld = CNT_W'(1);
    else if (int'(req) > MAX_WORDS)  words_ld = CNT_W'(MAX_WORDS);
    else                             words_ld = CNT_W'(req);
    busy_ld = xfer ? BUSY_W'(BUSY_CYC) : '0;
  end

  // late cancel counts only on the second enabled edge in execute
  assign cancel = !pass_i || (age_q == 2'd1 && late_cancel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= 1'b0;
      busy_q  <= '0;
      words_q <= '0;
      age_q   <= '0;
    end else if (adv_i) begin
      live_q  <= own;
      busy_q  <= busy_ld;
      words_q <= words_ld;
      age_q   <= '0;
    end else if (clk_en_i && live_q) begin
      if (cancel)                     live_q  <= 1'b0;
      else if (busy_q != '0)          busy_q  <= busy_q - 1'b1;
      else if (words_q > CNT_W'(1))   words_q <= words_q - 1'b1;
      else                            live_q  <= 1'b0;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  always_comb begin
    if (!live_q)                 hs = HS_ABSENT;
    else if (busy_q != '0)       hs = HS_WAIT;
    else if (words_q == CNT_W'(1)) hs = HS_LAST;
    else                         hs = HS_GO;
  end
  assign hs_ex_o = hs;

  p_last_retire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_ex_o == HS_LAST && clk_en_i && !adv_i && !cancel) |=> hs_ex_o == HS_ABSENT);

  p_go_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_ex_o == HS_GO && clk_en_i && !adv_i && !cancel) |=> words_q == $past(words_q) - 1'b1);

  p_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (words_q != '0 && words_q <= CNT_W'(MAX_WORDS)));

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> $stable(live_q) && $stable(busy_q) && $stable(words_q) && $stable(age_q));

  p_pass_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && clk_en_i && !adv_i && !pass_i) |=> hs_ex_o == HS_ABSENT);

  p_lc_window_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && clk_en_i && !adv_i && age_q == 2'd1 && late_cancel_i) |=> !live_q);

  p_lc_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_ex_o == HS_GO && clk_en_i && !adv_i && pass_i && age_q != 2'd1) |=> live_q);
endmodule

// File: rtl/cpf_follower.sv
module cpf_follower
  import cpf_pkg::*;
#(
  parameter logic [3:0] CP_ID     = 4'd5,
  parameter int         BUSY_CYC  = 2,
  parameter int         MAX_WORDS = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clk_en_i,
  input  logic            fetch_n_i,
  input  logic [IR_W-1:0] instr_i,
  input  logic            pass_i,
  input  logic            late_cancel_i,
  output logic [1:0]      hs_dec_o,
  output logic [1:0]      hs_ex_o
);
  logic            adv, dec_v;
  logic [IR_W-1:0] dec_ir;

  cpf_shadow_pipe u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_en_i  (clk_en_i),
    .fetch_n_i (fetch_n_i),
    .instr_i   (instr_i),
    .adv_o     (adv),
    .dec_v_o   (dec_v),
    .dec_ir_o  (dec_ir)
  );

  cpf_xfer_seq #(
    .CP_ID     (CP_ID),
    .BUSY_CYC  (BUSY_CYC),
    .MAX_WORDS (MAX_WORDS)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clk_en_i      (clk_en_i),
    .adv_i         (adv),
    .dec_v_i       (dec_v),
    .dec_ir_i      (dec_ir),
    .pass_i        (pass_i),
    .late_cancel_i (late_cancel_i),
    .hs_ex_o       (hs_ex_o)
  );

  assign hs_dec_o = (dec_v && cp_num(dec_ir) == CP_ID) ? HS_WAIT : HS_ABSENT;

  p_rst_absent_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (hs_dec_o == HS_ABSENT && hs_ex_o == HS_ABSENT));

  p_own_ex_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && hs_dec_o == HS_WAIT) |=> hs_ex_o != HS_ABSENT);

  p_foreign_ex_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && hs_dec_o == HS_ABSENT) |=> hs_ex_o == HS_ABSENT);
endmodule

// File: tb/sim_cpf_follower.sv
module sim_cpf_follower;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A = 2'b00, W = 2'b01, G = 2'b10, L = 2'b11;

  logic        clk = 1'b0, rst_ni = 1'b1;
  logic        clk_en = 1'b0, fetch_n = 1'b1, pass = 1'b0, lc = 1'b0;
  logic [31:0] instr = '0;
  logic [1:0]  hs_dec, hs_ex;

  typedef struct { logic [1:0] d; logic [1:0] e; string tag; } exp_t;
  exp_t sbq[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpf_follower u0 (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_i(clk_en), .fetch_n_i(fetch_n),
    .instr_i(instr), .pass_i(pass), .late_cancel_i(lc),
    .hs_dec_o(hs_dec), .hs_ex_o(hs_ex)
  );

  function automatic logic [31:0] mk(input logic [3:0] cp, input logic [7:0] cnt);
    return 32'h0C00_0000 | {20'd0, cp, 8'd0} | {24'd0, cnt};
  endfunction

  // monitor: compare one expected item per clock, after the edge settles
  always @(posedge clk) begin : mon
    exp_t x;
    #1;
    if (sbq.size() != 0) begin
      x = sbq.pop_front();
      n_chk++;
      if (hs_dec !== x.d || hs_ex !== x.e) begin
        n_fail++;
        $display("FAIL %s: dec=%b ex=%b expected dec=%b ex=%b", x.tag, hs_dec, hs_ex, x.d, x.e);
      end
    end
  end

  task automatic cyc(input logic en, input logic fn, input logic [31:0] ins,
                     input logic ps, input logic l,
                     input logic [1:0] ed, input logic [1:0] ee, input string tag);
    @(negedge clk);
    clk_en = en; fetch_n = fn; instr = ins; pass = ps; lc = l;
    sbq.push_back('{d: ed, e: ee, tag: tag});
  endtask

  task automatic idle(input logic ps, input logic l, input logic [1:0] ee, input string tag);
    cyc(1'b1, 1'b1, 32'd0, ps, l, A, ee, tag);
  endtask

  task automatic enter(input logic [31:0] w, input logic [1:0] de, input logic [1:0] ee,
                       input string tag);
    cyc(1'b1, 1'b0, 32'd0, 1'b1, 1'b0, A, A, tag);
    cyc(1'b1, 1'b0, w,     1'b1, 1'b0, A, A, tag);
    cyc(1'b1, 1'b0, 32'd0, 1'b1, 1'b0, de, A, tag);
    cyc(1'b1, 1'b0, 32'd0, 1'b1, 1'b0, A, ee, tag);
  endtask

  task automatic chk_now(input string tag);
    n_chk++;
    if (hs_dec !== A || hs_ex !== A) begin
      n_fail++;
      $display("FAIL %s: dec=%b ex=%b expected dec=%b ex=%b", tag, hs_dec, hs_ex, A, A);
    end
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk_now("R1 reset state");
    rst_ni = 1'b1;

    // R5: four-word transfer
    enter(mk(4'd5, 8'd4), W, W, "R5");
    idle(1, 0, W, "R5"); idle(1, 0, G, "R5"); idle(1, 0, G, "R5");
    idle(1, 0, G, "R5"); idle(1, 0, L, "R5"); idle(1, 0, A, "R5");

    // R4: foreign coprocessor number
    enter(mk(4'd3, 8'd4), A, A, "R4");
    idle(1, 0, A, "R4");

    // R7: owned non-transfer
    enter(32'h0E00_0500, W, L, "R7");
    idle(1, 0, A, "R7");

    // R6: cap at six words, and zero count
    enter(mk(4'd5, 8'd9), W, W, "R6");
    idle(1, 0, W, "R6");
    for (int i = 0; i < 5; i++) idle(1, 0, G, "R6");
    idle(1, 0, L, "R6"); idle(1, 0, A, "R6");
    enter(mk(4'd5, 8'd0), W, W, "R6 zero");
    idle(1, 0, W, "R6 zero"); idle(1, 0, L, "R6 zero"); idle(1, 0, A, "R6 zero");

    // R9: pass drops during wait, then during go
    enter(mk(4'd5, 8'd3), W, W, "R9");
    idle(1, 0, W, "R9"); idle(0, 0, A, "R9"); idle(1, 0, A, "R9");
    enter(mk(4'd5, 8'd3), W, W, "R9 go");
    idle(1, 0, W, "R9 go"); idle(1, 0, G, "R9 go"); idle(0, 0, A, "R9 go");

    // R10: cancel outside window ignored, inside window honoured
    enter(mk(4'd5, 8'd4), W, W, "R10 out");
    idle(1, 1, W, "R10 out"); idle(1, 0, G, "R10 out"); idle(1, 1, G, "R10 out");
    idle(1, 0, G, "R10 out"); idle(1, 0, L, "R10 out"); idle(1, 0, A, "R10 out");
    enter(mk(4'd5, 8'd4), W, W, "R10 in");
    idle(1, 0, W, "R10 in"); idle(1, 1, A, "R10 in");

    // R2 / R3: stalls hold decode; R8: enable low freezes execute
    cyc(1, 0, 32'd0,          1, 0, A, A, "R3");
    cyc(1, 0, mk(4'd5, 8'd2), 1, 0, A, A, "R3");
    cyc(1, 0, 32'd0,          1, 0, W, A, "R3");
    cyc(0, 0, 32'hFFFF_FFFF,  1, 0, W, A, "R2 en low");
    cyc(1, 1, 32'd0,          1, 0, W, A, "R2 no fetch");
    cyc(1, 1, 32'd0,          1, 0, W, A, "R2 no fetch");
    cyc(1, 0, 32'd0,          1, 0, A, W, "R2 advance");
    idle(1, 0, W, "R8");
    cyc(0, 1, 32'd0, 1, 0, A, W, "R8 frozen");
    cyc(0, 1, 32'd0, 0, 1, A, W, "R8 pass ignored");
    idle(1, 0, G, "R8"); 
    cyc(0, 1, 32'd0, 1, 0, A, G, "R8 frozen go");
    idle(1, 0, L, "R8"); idle(1, 0, A, "R8");

    // R1: reset mid-transfer, then clean restart
    enter(mk(4'd5, 8'd4), W, W, "R1 pre");
    idle(1, 0, W, "R1 pre");
    @(negedge clk);
    rst_ni = 1'b0;
    #1 chk_now("R1 mid-run reset");
    @(negedge clk);
    rst_ni = 1'b1;
    enter(mk(4'd5, 8'd1), W, W, "R1 restart");
    idle(1, 0, W, "R1 restart"); idle(1, 0, L, "R1 restart"); idle(1, 0, A, "R1 restart");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule